// File: doc/BRIEF.md
# Accumulator Round-and-Saturate Unit

This unit turns a pair of wide accumulators into a rounded, clamped 32-bit signed result. The upper accumulator and the low half-word of the lower accumulator are joined into one 56-bit signed operand. That operand is scaled by a signed shift count. A half-unit is then added below the 16-bit cut point, and the value is truncated there. The result is taken as a 44-bit signed quantity and limited to the signed 32-bit range.

The result leaves the unit as two 16-bit words, high and low. The unit also keeps an overflow flag, plus a one-deep history of that flag. A caller places the operands and the shift count on the inputs and pulses `start` for one cycle. The result and both flags appear on the next clock edge. They stay unchanged until the next pulse. The datapath is a single combinational stage feeding one register bank. It has no multi-cycle state.

Top module: `acc_round_sat`

## Requirements
- R1: The operand is `acc_a` (40 bits, two's complement) placed above `acc_b[15:0]`, giving a 56-bit value. Bit 39 of `acc_a` is its sign. Bits 39:16 of `acc_b` have no effect on any output.
- R2: A shift count of zero or more shifts the operand left by that many places. A negative count shifts it right arithmetically by its magnitude, copying the sign bit.
- R3: `shamt` is a 6-bit two's complement value. Counts above +16 act as +16, and counts below −16 act as −16.
- R4: Rounding adds 0x8000 to the shifted value and then shifts arithmetically right by 16. A fraction of exactly one half therefore rounds toward plus infinity.
- R5: Bits 43:0 of the rounded value, read as a signed 44-bit number, are compared with +0x7FFFFFFF and −0x80000000. Rounded bits above bit 43 take no part in this comparison.
- R6: If the 44-bit value exceeds +0x7FFFFFFF, the result is `res_hi`=0x7FFF and `res_lo`=0xFFFF, and `ovf` becomes 1.
- R7: If the 44-bit value is below −0x80000000, the result is `res_hi`=0x8000 and `res_lo`=0x0000, and `ovf` becomes 1.
- R8: Otherwise `res_hi` takes bits 31:16 and `res_lo` takes bits 15:0 of the rounded value, and `ovf` becomes 0. Exact limit values do not saturate.
- R9: At each `start`, `ovf_prev` takes the value `ovf` had before that update.
- R10: Results and flags change only on the rising edge that samples `start`=1. They hold their values in every other cycle.
- R11: While `rst_n` is low, `res_hi`, `res_lo`, `ovf` and `ovf_prev` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (asynchronous assert) |
| start | input | 1 | One-cycle request to compute and register a result |
| acc_a | input | 40 | Upper accumulator, two's complement |
| acc_b | input | 40 | Lower accumulator; only bits 15:0 are used |
| shamt | input | 6 | Signed shift count, clamped to ±16 |
| res_hi | output | 16 | Result bits 31:16 |
| res_lo | output | 16 | Result bits 15:0 |
| ovf | output | 1 | Saturation occurred on the last request |
| ovf_prev | output | 1 | Value of `ovf` before the last request |

## Verification
The vector walk runs plain values at shift zero with fractions just below and exactly at one half. These separate truncation from round-half-up, and they show whether a negative tie moves toward zero. Values at, and one step beyond, each 32-bit limit separate an inclusive comparison from an exclusive one. They also separate a saturated output from a genuine 0x7FFFFFFF or 0x80000000 result.

Left and right shifts of negative and positive operands show whether the right shift is arithmetic. Counts of +31 and −32 give results that differ from their clamped ±16 forms. Two left-shifted operands whose rounded value spills past bit 43 show whether the limit check really uses only the 44-bit view. Junk in the unused upper bits of `acc_b` shows that those bits are ignored. Running the vectors back to back, followed by a hold test and a mid-run reset, exposes the flag history and the update timing.

// File: rtl/ars_pkg.sv
package ars_pkg;

    localparam int ARS_ACC_W     = 40;
    localparam int ARS_HALF_W    = 16;
    localparam int ARS_SHAMT_W   = 6;
    localparam int ARS_SHIFT_LIM = 16;
    localparam int ARS_VIEW_W    = 44;

    typedef enum logic {
        SH_LEFT  = 1'b0,
        SH_RIGHT = 1'b1
    } sh_dir_e;

    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_POS  = 2'd1,
        SAT_NEG  = 2'd2
    } sat_kind_e;

endpackage

// File: rtl/ars_operand.sv
module ars_operand #(
    parameter int ACC_W  = 40,
    parameter int HALF_W = 16,
    parameter int WORK_W = 72
) (
    input  logic [ACC_W-1:0]         acc_a,
    input  logic [ACC_W-1:0]         acc_b,
    output logic signed [WORK_W-1:0] op_ext
);
    localparam int OP_W = ACC_W + HALF_W;

    logic signed [OP_W-1:0] joined;
    logic [ACC_W-HALF_W-1:0] unused_b_hi;

    // upper accumulator sits above the low half-word of the lower one
    assign joined      = $signed({acc_a, acc_b[HALF_W-1:0]});
    assign unused_b_hi = acc_b[ACC_W-1:HALF_W];

    // sign-extend into the working width
    assign op_ext = WORK_W'(joined);
endmodule

// File: rtl/ars_shifter.sv
module ars_shifter
    import ars_pkg::*;
#(
    parameter int SHAMT_W   = 6,
    parameter int SHIFT_LIM = 16,
    parameter int WORK_W    = 72
) (
    input  logic signed [WORK_W-1:0]  op_in,
    input  logic signed [SHAMT_W-1:0] shamt,
    output logic signed [WORK_W-1:0]  op_out
);
    localparam logic signed [SHAMT_W-1:0] POS_LIM = SHAMT_W'(SHIFT_LIM);
    localparam logic signed [SHAMT_W-1:0] NEG_LIM = -POS_LIM;

    logic signed [SHAMT_W-1:0] cnt_clamped;
    logic [SHAMT_W-1:0]        mag;
    sh_dir_e                   dir;

    always_comb begin
        if (shamt > POS_LIM)
            cnt_clamped = POS_LIM;
        else if (shamt < NEG_LIM)
            cnt_clamped = NEG_LIM;
        else
            cnt_clamped = shamt;
    end

    always_comb begin
        if (cnt_clamped[SHAMT_W-1]) begin
            dir = SH_RIGHT;
            mag = SHAMT_W'(-cnt_clamped);
        end else begin
            dir = SH_LEFT;
            mag = cnt_clamped;
        end
    end

    always_comb begin
        unique case (dir)
            SH_LEFT:  op_out = op_in <<< mag;
            SH_RIGHT: op_out = op_in >>> mag;
            default:  op_out = op_in;
        endcase
    end
endmodule

// File: rtl/ars_round_sat.sv
module ars_round_sat
    import ars_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int VIEW_W = 44,
    parameter int WORK_W = 72
) (
    input  logic signed [WORK_W-1:0] shifted,
    output sat_kind_e                kind,
    output logic [2*HALF_W-1:0]      word
);
    localparam int RES_W = 2 * HALF_W;
    localparam logic signed [WORK_W-1:0] HALF_LSB = WORK_W'(1) << (HALF_W - 1);
    localparam logic signed [VIEW_W-1:0] MAX_V =
        {{(VIEW_W-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}};
    localparam logic signed [VIEW_W-1:0] MIN_V =
        {{(VIEW_W-RES_W+1){1'b1}}, {(RES_W-1){1'b0}}};

    logic signed [WORK_W-1:0] biased;
    logic signed [VIEW_W-1:0] view;
    logic [HALF_W-1:0]        unused_frac;
    logic [WORK_W-VIEW_W-HALF_W-1:0] unused_top;

    assign biased = shifted + HALF_LSB;
    // drop the fraction; keep a 44-bit signed window above it
    assign view        = biased[VIEW_W+HALF_W-1:HALF_W];
    assign unused_frac = biased[HALF_W-1:0];
    assign unused_top  = biased[WORK_W-1:VIEW_W+HALF_W];

    always_comb begin
        if (view > MAX_V)
            kind = SAT_POS;
        else if (view < MIN_V)
            kind = SAT_NEG;
        else
            kind = SAT_NONE;
    end

    assign word = view[RES_W-1:0];
endmodule

// File: rtl/acc_round_sat.sv
module acc_round_sat
    import ars_pkg::*;
#(
    parameter int ACC_W     = ARS_ACC_W,
    parameter int HALF_W    = ARS_HALF_W,
    parameter int SHAMT_W   = ARS_SHAMT_W,
    parameter int SHIFT_LIM = ARS_SHIFT_LIM,
    parameter int VIEW_W    = ARS_VIEW_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ACC_W-1:0]   acc_a,
    input  logic [ACC_W-1:0]   acc_b,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [HALF_W-1:0]  res_hi,
    output logic [HALF_W-1:0]  res_lo,
    output logic               ovf,
    output logic               ovf_prev
);
    localparam int RES_W  = 2 * HALF_W;
    localparam int WORK_W = ACC_W + HALF_W + SHIFT_LIM;
    localparam logic [RES_W-1:0] POS_WORD = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] NEG_WORD = {1'b1, {(RES_W-1){1'b0}}};

    logic signed [WORK_W-1:0] op_ext;
    logic signed [WORK_W-1:0] op_shifted;
    sat_kind_e                kind;
    logic [RES_W-1:0]         raw_word;
    logic [RES_W-1:0]         next_word;
    logic                     next_ovf;

    ars_operand #(
        .ACC_W (ACC_W),
        .HALF_W(HALF_W),
        .WORK_W(WORK_W)
    ) u_operand (
        .acc_a (acc_a),
        .acc_b (acc_b),
        .op_ext(op_ext)
    );

    ars_shifter #(
        .SHAMT_W  (SHAMT_W),
        .SHIFT_LIM(SHIFT_LIM),
        .WORK_W   (WORK_W)
    ) u_shifter (
        .op_in (op_ext),
        .shamt ($signed(shamt)),
        .op_out(op_shifted)
    );

    ars_round_sat #(
        .HALF_W(HALF_W),
        .VIEW_W(VIEW_W),
        .WORK_W(WORK_W)
    ) u_round_sat (
        .shifted(op_shifted),
        .kind   (kind),
        .word   (raw_word)
    );

    // output selection
    always_comb begin
        unique case (kind)
            SAT_POS: begin
                next_word = POS_WORD;
                next_ovf  = 1'b1;
            end
            SAT_NEG: begin
                next_word = NEG_WORD;
                next_ovf  = 1'b1;
            end
            default: begin
                next_word = raw_word;
                next_ovf  = 1'b0;
            end
        endcase
    end

    // result register bank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_hi   <= '0;
            res_lo   <= '0;
            ovf      <= 1'b0;
            ovf_prev <= 1'b0;
        end else if (start) begin
            ovf_prev <= ovf;
            ovf      <= next_ovf;
            res_hi   <= next_word[RES_W-1:HALF_W];
            res_lo   <= next_word[HALF_W-1:0];
        end
    end

    // R10
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(res_hi) && $stable(res_lo) && $stable(ovf) && $stable(ovf_prev)));

    // R9
    history_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (ovf_prev == $past(ovf)));

    // R6 R7
    sat_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> ({res_hi, res_lo} == POS_WORD || {res_hi, res_lo} == NEG_WORD));

    // R1
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && acc_a == '0 && acc_b[HALF_W-1:0] == '0) |=>
            (res_hi == '0 && res_lo == '0 && !ovf));
endmodule

// File: tb/tb_acc_round_sat.sv
module tb_acc_round_sat;

    typedef struct packed {
        logic [39:0] a;
        logic [39:0] b;
        logic [5:0]  sh;
        logic [15:0] hi;
        logic [15:0] lo;
        logic        ov;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{40'h0000000001, 40'h0000008000, 6'h00, 16'h0000, 16'h0002, 1'b0},
        '{40'h0000001234, 40'h0000007FFF, 6'h00, 16'h0000, 16'h1234, 1'b0},
        '{40'h007FFFFFFF, 40'h0000000000, 6'h00, 16'h7FFF, 16'hFFFF, 1'b0},
        '{40'h0080000000, 40'h0000000000, 6'h00, 16'h7FFF, 16'hFFFF, 1'b1},
        '{40'hFF80000000, 40'h0000000000, 6'h00, 16'h8000, 16'h0000, 1'b0},
        '{40'hFF7FFFFFFF, 40'h0000000000, 6'h00, 16'h8000, 16'h0000, 1'b1},
        '{40'h0000000000, 40'h0000000001, 6'h10, 16'h0000, 16'h0001, 1'b0},
        '{40'h0000000100, 40'h0000000000, 6'h3C, 16'h0000, 16'h0010, 1'b0},
        '{40'hFFFFFFFF00, 40'h0000000000, 6'h3C, 16'hFFFF, 16'hFFF0, 1'b0},
        '{40'h0000000000, 40'h0000000001, 6'h1F, 16'h0000, 16'h0001, 1'b0},
        '{40'h0000010000, 40'h0000000000, 6'h20, 16'h0000, 16'h0001, 1'b0},
        '{40'h0000000000, 40'hFFFFFF8000, 6'h00, 16'h0000, 16'h0001, 1'b0},
        '{40'h1000000000, 40'h0000000000, 6'h10, 16'h0000, 16'h0000, 1'b0},
        '{40'h0008000000, 40'h0000000000, 6'h10, 16'h8000, 16'h0000, 1'b1},
        '{40'h0000008000, 40'h0000000000, 6'h10, 16'h7FFF, 16'hFFFF, 1'b1},
        '{40'hFFFFFFFFFF, 40'h0000008000, 6'h00, 16'h0000, 16'h0000, 1'b0}
    };

    localparam string TAGS [NV] = '{
        "R4 R8 round up", "R4 R8 round down", "R8 upper limit exact",
        "R6 positive overflow", "R8 lower limit exact", "R7 negative overflow",
        "R2 left shift", "R2 right shift", "R2 arithmetic right shift",
        "R3 clamp +31", "R3 clamp -32", "R1 acc_b upper ignored",
        "R5 view wraps to zero", "R5 R7 view bit 43", "R6 left shift saturate",
        "R4 negative half tie"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [39:0] acc_a = '0;
    logic [39:0] acc_b = '0;
    logic [5:0]  shamt = '0;
    logic [15:0] res_hi;
    logic [15:0] res_lo;
    logic        ovf;
    logic        ovf_prev;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    acc_round_sat dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .acc_a   (acc_a),
        .acc_b   (acc_b),
        .shamt   (shamt),
        .res_hi  (res_hi),
        .res_lo  (res_lo),
        .ovf     (ovf),
        .ovf_prev(ovf_prev)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic check_all(input string tag, input logic [15:0] hi, input logic [15:0] lo,
                             input logic ov, input logic pv);
        check(tag, {res_hi, res_lo}, {hi, lo});
        check({tag, " ovf"}, {31'd0, ovf}, {31'd0, ov});
        check({tag, " R9 ovf_prev"}, {31'd0, ovf_prev}, {31'd0, pv});
    endtask

    task automatic apply(input logic [39:0] a, input logic [39:0] b, input logic [5:0] s);
        @(negedge clk);
        acc_a = a;
        acc_b = b;
        shamt = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic prev_ov;
        repeat (3) @(negedge clk);
        // R11 reset state
        check_all("R11 reset", 16'h0000, 16'h0000, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 update on edge after start, walk of vectors
        prev_ov = 1'b0;
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].a, VECS[i].b, VECS[i].sh);
            check_all(TAGS[i], VECS[i].hi, VECS[i].lo, VECS[i].ov, prev_ov);
            prev_ov = VECS[i].ov;
        end

        // R10 hold without start: saturating inputs must not appear
        @(negedge clk);
        acc_a = 40'h0080000000;
        acc_b = 40'h0;
        shamt = 6'h00;
        repeat (3) @(negedge clk);
        check_all("R10 hold", 16'h0000, 16'h0000, 1'b0, 1'b1);

        // R9 consecutive overflows then recovery
        apply(40'hFF7FFFFFFF, 40'h0, 6'h00);
        check_all("R9 R7 after hold", 16'h8000, 16'h0000, 1'b1, 1'b0);
        apply(40'h0000000002, 40'h0, 6'h00);
        check_all("R9 R8 recovery", 16'h0000, 16'h0002, 1'b0, 1'b1);

        // R11 reset in mid-run after saturation
        apply(40'h0080000000, 40'h0, 6'h00);
        check_all("R6 before reset", 16'h7FFF, 16'hFFFF, 1'b1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R11 mid-run reset", 16'h0000, 16'h0000, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule